// File: doc/BRIEF.md
# Card Identification Command Sequencer

This block is the host-side controller that walks a freshly attached memory card from bus activation to the data transfer state. A start pulse, together with a card-kind selector, chooses one of three command orderings. The block then asks a separate command-line shifter for each identification command. It presents an index, an argument and the expected response kind, and it waits for a done or error pulse. The card's 128-bit identity word and its 16-bit relative address are kept from the responses.

When several cards share the bus, the identity/address cycle runs once per card. The address request can be repeated a chosen number of times, and the last reply wins. A single clock-select output keeps the card clock on the slow identification divider until every card is addressed. It then switches to the fast transfer divider, and a one-cycle completion flag marks that moment. A failed response parks the block in a sticky fault state, which only a new start pulse leaves.

Top module: `card_ident_seq`

## Requirements
- R1: After reset, cmd_valid, clk_fast, fault and done are all 0, and cid and rca are 0.
- R2: For card_kind 0 (SD memory), and for the unused code 3 which behaves the same, the commands run in the order index 2 then index 3. Index 2 expects a long response (cmd_rsp = 2) and index 3 expects a short one (cmd_rsp = 1).
- R3: For card_kind 1 (I/O card), the only command issued is index 3. No index 2 is sent, and cid keeps its previous value.
- R4: For card_kind 2 (multimedia card), index 1 comes first, with argument OCR_ARG and a short response. Index 2 follows, then index 3.
- R5: Each card receives 1 + rca_repeat index-3 commands in a row. rca holds the value from the most recent of them.
- R6: For card kinds 0 and 2, the index-2/index-3 cycle repeats for card_count cards, and a count of 0 is taken as 1. Card kind 1 always runs a single cycle.
- R7: On an accepted index-2 response, cid takes all 128 bits of rsp_data. On an accepted index-3 response, rca takes rsp_data[31:16].
- R8: clk_fast is 0 from start until the last accepted index-3 response. It rises at the same edge as done and stays 1 in the transfer state.
- R9: done is high for exactly one cycle, on entry to the transfer state.
- R10: rsp_err while a command is pending ends the sequence. fault then stays 1 and cmd_valid stays 0, and rsp_err takes priority over a simultaneous rsp_done. Only a start pulse clears fault.
- R11: A start pulse while a command is pending is ignored. rsp_done arriving with no command pending changes neither cid nor rca.
- R12: While a command is pending, cmd_valid stays 1 and cmd_idx, cmd_arg and cmd_rsp stay unchanged until rsp_done or rsp_err. The next command appears in the cycle after the response pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins identification |
| card_kind | input | 2 | 0 SD memory, 1 I/O card, 2 multimedia card |
| card_count | input | CNT_W | Number of cards on the bus (0 treated as 1) |
| rca_repeat | input | RPT_W | Extra address requests per card |
| rsp_done | input | 1 | Response received for the pending command |
| rsp_err | input | 1 | Response failed or timed out |
| rsp_data | input | 128 | Response payload; short responses use bits 31:0 |
| cmd_valid | output | 1 | A command request is pending |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp | output | 2 | Expected response: 0 none, 1 short, 2 long |
| cid | output | 128 | Captured card identity |
| rca | output | 16 | Captured relative card address |
| clk_fast | output | 1 | 0 slow identification divider, 1 fast transfer divider |
| fault | output | 1 | Sticky error status |
| done | output | 1 | One-cycle pulse on entering transfer state |

## Verification
Each result is registered once, so it is due one cycle after the stimulus that causes it. The first command is visible one cycle after start. A new command or the fault flag appears one cycle after a response pulse. The captured cid or rca is updated in the cycle after its response. done and clk_fast appear one cycle after the final address reply, and done drops one cycle later. The bench drives every pulse on the falling edge and samples on the next falling edge, which lands exactly in the cycle where each result is due. A sweep over all card kinds, card counts from 0 to 3 and repeat counts from 0 to 2 predicts the full command list and the final captured values arithmetically.

// File: rtl/cis_pkg.sv
package cis_pkg;

    typedef enum logic [1:0] {
        CARD_SD   = 2'd0,
        CARD_SDIO = 2'd1,
        CARD_MMC  = 2'd2
    } card_kind_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_SHORT = 2'd1,
        RSP_LONG  = 2'd2
    } rsp_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_XFER  = 2'd2,
        PH_FAULT = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        STEP_OPCOND = 2'd0,
        STEP_CID    = 2'd1,
        STEP_ADDR   = 2'd2
    } step_e;

    localparam int IDX_W = 6;
    localparam int ARG_W = 32;
    localparam int CID_W = 128;
    localparam int RCA_W = 16;

    localparam logic [IDX_W-1:0] IDX_OPCOND = 6'd1;
    localparam logic [IDX_W-1:0] IDX_CID    = 6'd2;
    localparam logic [IDX_W-1:0] IDX_ADDR   = 6'd3;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
        rsp_kind_e        rsp;
    } cmd_req_t;

    function automatic step_e first_step(input logic [1:0] kind);
        case (kind)
            CARD_MMC:  return STEP_OPCOND;
            CARD_SDIO: return STEP_ADDR;
            default:   return STEP_CID;
        endcase
    endfunction

endpackage

// File: rtl/cis_cmd_table.sv
module cis_cmd_table
    import cis_pkg::*;
#(
    parameter logic [31:0] OCR_ARG = 32'h40FF_8000
) (
    input  step_e    step,
    output cmd_req_t req
);
    always_comb begin
        req = '{idx: IDX_CID, arg: '0, rsp: RSP_LONG};
        case (step)
            STEP_OPCOND: req = '{idx: IDX_OPCOND, arg: OCR_ARG, rsp: RSP_SHORT};
            STEP_ADDR:   req = '{idx: IDX_ADDR,   arg: '0,      rsp: RSP_SHORT};
            default:     req = '{idx: IDX_CID,    arg: '0,      rsp: RSP_LONG};
        endcase
    end
endmodule

// File: rtl/cis_seq_fsm.sv
module cis_seq_fsm
    import cis_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int RPT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       card_kind,
    input  logic [CNT_W-1:0] card_count,
    input  logic [RPT_W-1:0] rca_repeat,
    input  logic             rsp_done,
    input  logic             rsp_err,
    output phase_e           phase,
    output step_e            step,
    output logic             cap_cid,
    output logic             cap_rca,
    output logic             done,
    output logic             clk_fast
);
    logic [1:0]       kind_q;
    logic [CNT_W-1:0] cards_left;
    logic [RPT_W-1:0] rep_cnt;
    logic [RPT_W-1:0] rep_lim;
    logic             accept;
    logic             more_cards;

    assign accept     = (phase == PH_WAIT) && rsp_done && !rsp_err;
    assign cap_cid    = accept && (step == STEP_CID);
    assign cap_rca    = accept && (step == STEP_ADDR);
    assign more_cards = (kind_q != CARD_SDIO) && (cards_left > CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            step       <= STEP_CID;
            kind_q     <= CARD_SD;
            cards_left <= '0;
            rep_cnt    <= '0;
            rep_lim    <= '0;
            done       <= 1'b0;
            clk_fast   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && phase != PH_WAIT) begin
                phase      <= PH_WAIT;
                kind_q     <= card_kind;
                step       <= first_step(card_kind);
                cards_left <= (card_count == '0) ? CNT_W'(1) : card_count;
                rep_lim    <= rca_repeat;
                rep_cnt    <= '0;
                clk_fast   <= 1'b0;
            end else if (phase == PH_WAIT) begin
                if (rsp_err) begin
                    phase <= PH_FAULT;
                end else if (rsp_done) begin
                    case (step)
                        STEP_OPCOND: step <= STEP_CID;
                        STEP_CID: begin
                            step    <= STEP_ADDR;
                            rep_cnt <= '0;
                        end
                        default: begin
                            if (rep_cnt != rep_lim) begin
                                rep_cnt <= rep_cnt + RPT_W'(1);
                            end else if (more_cards) begin
                                cards_left <= cards_left - CNT_W'(1);
                                step       <= STEP_CID;
                            end else begin
                                phase    <= PH_XFER;
                                done     <= 1'b1;
                                clk_fast <= 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/cis_id_store.sv
module cis_id_store
    import cis_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_cid,
    input  logic             cap_rca,
    input  logic [CID_W-1:0] rsp_data,
    output logic [CID_W-1:0] cid,
    output logic [RCA_W-1:0] rca
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cid <= '0;
            rca <= '0;
        end else begin
            if (cap_cid) cid <= rsp_data;
            if (cap_rca) rca <= rsp_data[31:16];
        end
    end
endmodule

// File: rtl/card_ident_seq.sv
module card_ident_seq
    import cis_pkg::*;
#(
    parameter int          CNT_W   = 3,
    parameter int          RPT_W   = 2,
    parameter logic [31:0] OCR_ARG = 32'h40FF_8000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       card_kind,
    input  logic [CNT_W-1:0] card_count,
    input  logic [RPT_W-1:0] rca_repeat,
    input  logic             rsp_done,
    input  logic             rsp_err,
    input  logic [127:0]     rsp_data,
    output logic             cmd_valid,
    output logic [5:0]       cmd_idx,
    output logic [31:0]      cmd_arg,
    output logic [1:0]       cmd_rsp,
    output logic [127:0]     cid,
    output logic [15:0]      rca,
    output logic             clk_fast,
    output logic             fault,
    output logic             done
);
    phase_e   phase;
    step_e    step;
    cmd_req_t req;
    logic     cap_cid;
    logic     cap_rca;

    cis_seq_fsm #(.CNT_W(CNT_W), .RPT_W(RPT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .card_kind  (card_kind),
        .card_count (card_count),
        .rca_repeat (rca_repeat),
        .rsp_done   (rsp_done),
        .rsp_err    (rsp_err),
        .phase      (phase),
        .step       (step),
        .cap_cid    (cap_cid),
        .cap_rca    (cap_rca),
        .done       (done),
        .clk_fast   (clk_fast)
    );

    cis_cmd_table #(.OCR_ARG(OCR_ARG)) u_table (
        .step (step),
        .req  (req)
    );

    cis_id_store u_store (
        .clk      (clk),
        .rst      (rst),
        .cap_cid  (cap_cid),
        .cap_rca  (cap_rca),
        .rsp_data (rsp_data),
        .cid      (cid),
        .rca      (rca)
    );

    assign cmd_valid = (phase == PH_WAIT);
    assign fault     = (phase == PH_FAULT);
    assign cmd_idx   = req.idx;
    assign cmd_arg   = req.arg;
    assign cmd_rsp   = req.rsp;
endmodule

// File: rtl/cis_checker.sv
module cis_checker (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         rsp_done,
    input logic         rsp_err,
    input logic [127:0] rsp_data,
    input logic         cmd_valid,
    input logic [5:0]   cmd_idx,
    input logic [15:0]  rca,
    input logic         clk_fast,
    input logic         fault,
    input logic         done
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_FAST_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_fast) |-> done); // R8
    AST_SLOW_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !clk_fast); // R8
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fault && !start) |=> fault); // R10
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
        fault |-> !cmd_valid); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !rsp_done && !rsp_err) |=> (cmd_valid && $stable(cmd_idx))); // R12
    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && rsp_done && !rsp_err && cmd_idx == 6'd3) |=> (rca == $past(rsp_data[31:16]))); // R7
    AST_IDX_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_idx == 6'd1 || cmd_idx == 6'd2 || cmd_idx == 6'd3)); // R2
endmodule

bind card_ident_seq cis_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .cmd_valid (cmd_valid),
    .cmd_idx   (cmd_idx),
    .rca       (rca),
    .clk_fast  (clk_fast),
    .fault     (fault),
    .done      (done)
);

// File: tb/card_ident_seq_test.sv
module card_ident_seq_test;
    localparam int          CNT_W = 3;
    localparam int          RPT_W = 2;
    localparam logic [31:0] OCR   = 32'h40FF_8000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [1:0]       card_kind = 2'd0;
    logic [CNT_W-1:0] card_count = '0;
    logic [RPT_W-1:0] rca_repeat = '0;
    logic             rsp_done = 1'b0;
    logic             rsp_err = 1'b0;
    logic [127:0]     rsp_data = '0;
    logic             cmd_valid;
    logic [5:0]       cmd_idx;
    logic [31:0]      cmd_arg;
    logic [1:0]       cmd_rsp;
    logic [127:0]     cid;
    logic [15:0]      rca;
    logic             clk_fast;
    logic             fault;
    logic             done;

    int checks = 0;
    int failures = 0;
    logic [127:0] exp_cid = '0;
    logic [15:0]  exp_rca = '0;

    always #10 clk = ~clk;

    card_ident_seq #(.CNT_W(CNT_W), .RPT_W(RPT_W), .OCR_ARG(OCR)) uut (
        .clk(clk), .rst(rst), .start(start), .card_kind(card_kind),
        .card_count(card_count), .rca_repeat(rca_repeat),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_rsp(cmd_rsp), .cid(cid), .rca(rca), .clk_fast(clk_fast),
        .fault(fault), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input int kind, input int cnt, input int rep);
        card_kind  = 2'(kind);
        card_count = CNT_W'(cnt);
        rca_repeat = RPT_W'(rep);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // a command is expected pending now; check it, then answer it
    task automatic serve(input string req, input int idx, input int rk,
                         input logic [31:0] arg, input logic [127:0] d);
        chk("R12", "cmd_valid", 128'(cmd_valid), 128'd1);
        chk(req, "cmd_idx", 128'(cmd_idx), 128'(idx));
        chk("R2", "cmd_rsp", 128'(cmd_rsp), 128'(rk));
        chk(req, "cmd_arg", 128'(cmd_arg), 128'(arg));
        chk("R8", "clk_fast low", 128'(clk_fast), 128'd0);
        rsp_done = 1'b1;
        rsp_data = d;
        @(negedge clk);
        rsp_done = 1'b0;
        rsp_data = '0;
    endtask

    task automatic run_seq(input int kind, input int cnt, input int rep, input int id);
        int ncards;
        string tag;
        tag = (kind == 1) ? "R3" : ((kind == 2) ? "R4" : "R2");
        ncards = (kind == 1) ? 1 : ((cnt == 0) ? 1 : cnt);
        pulse_start(kind, cnt, rep);
        if (kind == 2) serve("R4", 1, 1, OCR, 128'h0);
        for (int c = 0; c < ncards; c++) begin
            if (kind != 1) begin
                logic [127:0] cv;
                cv = {32'(id), 32'(c), 32'hC1D0_0000 + 32'(id * 8 + c), ~32'(id)};
                serve(tag, 2, 2, 32'h0, cv);
                exp_cid = cv;
                chk("R7", "cid after index 2", cid, exp_cid);
            end
            for (int r = 0; r <= rep; r++) begin
                logic [15:0] rv;
                rv = 16'h1000 + 16'(id * 64 + c * 8 + r);
                serve((r > 0) ? "R5" : "R6", 3, 1, 32'h0, {96'h0, rv, 16'h0500});
                exp_rca = rv;
                chk("R5", "rca after index 3", 128'(rca), 128'(exp_rca));
            end
        end
        chk("R9", "done on entry", 128'(done), 128'd1);
        chk("R8", "clk_fast on entry", 128'(clk_fast), 128'd1);
        chk("R6", "no further command", 128'(cmd_valid), 128'd0);
        @(negedge clk);
        chk("R9", "done dropped", 128'(done), 128'd0);
        chk("R8", "clk_fast held", 128'(clk_fast), 128'd1);
        chk("R3", "cid final", cid, exp_cid);
        chk("R5", "rca final", 128'(rca), 128'(exp_rca));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int id;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "cmd_valid", 128'(cmd_valid), 128'd0);
        chk("R1", "clk_fast", 128'(clk_fast), 128'd0);
        chk("R1", "fault", 128'(fault), 128'd0);
        chk("R1", "done", 128'(done), 128'd0);
        chk("R1", "cid", cid, 128'd0);
        chk("R1", "rca", 128'(rca), 128'd0);

        id = 1;
        for (int k = 0; k < 3; k++)
            for (int n = 0; n < 4; n++)
                for (int r = 0; r < 3; r++) begin
                    run_seq(k, n, r, id);
                    id++;
                end
        run_seq(3, 2, 1, id);   // unused code behaves as SD memory
        id++;

        // R11: response with nothing pending leaves the store alone
        rsp_done = 1'b1;
        rsp_data = {128{1'b1}};
        @(negedge clk);
        rsp_done = 1'b0;
        rsp_data = '0;
        @(negedge clk);
        chk("R11", "cid unchanged idle", cid, exp_cid);
        chk("R11", "rca unchanged idle", 128'(rca), 128'(exp_rca));

        // R10: error on the identity command
        pulse_start(0, 1, 0);
        chk("R8", "clk_fast back to slow", 128'(clk_fast), 128'd0);
        rsp_err = 1'b1;
        rsp_done = 1'b1;
        rsp_data = {128{1'b1}};
        @(negedge clk);
        rsp_err = 1'b0;
        rsp_done = 1'b0;
        rsp_data = '0;
        chk("R10", "fault set", 128'(fault), 128'd1);
        chk("R10", "no request in fault", 128'(cmd_valid), 128'd0);
        chk("R10", "err beats done cid", cid, exp_cid);
        repeat (3) @(negedge clk);
        chk("R10", "fault sticky", 128'(fault), 128'd1);
        rsp_done = 1'b1;
        rsp_data = {96'h0, 16'hBEEF, 16'h0};
        @(negedge clk);
        rsp_done = 1'b0;
        rsp_data = '0;
        chk("R11", "rca unchanged in fault", 128'(rca), 128'(exp_rca));
        chk("R10", "fault still set", 128'(fault), 128'd1);

        // R11: start while pending is ignored
        pulse_start(1, 1, 0);
        chk("R10", "start clears fault", 128'(fault), 128'd0);
        chk("R3", "I/O card first index", 128'(cmd_idx), 128'd3);
        pulse_start(2, 1, 0);
        chk("R11", "start ignored idx", 128'(cmd_idx), 128'd3);
        chk("R11", "start ignored valid", 128'(cmd_valid), 128'd1);
        repeat (2) @(negedge clk);
        chk("R12", "request held idx", 128'(cmd_idx), 128'd3);
        serve("R3", 3, 1, 32'h0, {96'h0, 16'h7A7A, 16'h0});
        chk("R9", "done after I/O", 128'(done), 128'd1);
        chk("R7", "rca from bits 31:16", 128'(rca), 128'h7A7A);
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule